// File: doc/BRIEF.md
# Maskable Interrupt Prioritizer With Promotion

This block takes twenty raw maskable interrupt requests and turns them into one registered interrupt request and the number of the vector that should be taken. Each request is first qualified by its local enable bit, except the external request line, which has no enable. The whole set is then blocked by a global mask bit. Qualified requests are folded onto fifteen vectors. Most vectors carry a single source. Two sources share one vector, and the five serial-port conditions share another.

The vectors are ranked by a fixed default order in which a lower vector number has higher priority. A 4-bit promotion code can lift any one vector above all others. The promotion code sits in a small register that accepts a write only in a cycle where the global mask is set. A code that names no vector leaves the default order in force. Once the block raises a request, it keeps the request and the vector number frozen until the consumer acknowledges. On the acknowledge cycle it loads the current arbitration result.

Top module: `irq_prioritizer`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0 and the promotion code is 0, so promoting vector 0 gives the same order as the default.
- R2: While imask_i is 1, no source can raise irq_o.
- R3: Source 0, the external request, has no local enable. A source s in 1..18 is qualified by en_i[s-1].
- R4: Sources 15..19 are the serial conditions: transmit complete, transmit empty, idle line, receive overrun and receive full. All five map to vector 14, and sources 18 and 19 share en_i[17].
- R5: Source 0 maps to vector 0. A source s in 1..12 maps to vector s. Sources 13 and 14 both map to vector 13.
- R6: With no effective promotion, the pending vector with the lowest number wins.
- R7: With a promotion code p in 0..14 and vector p pending, vector p wins over every other pending vector.
- R8: A promotion code of 15 names no vector, and arbitration then follows the default order.
- R9: sel_wdata_i is stored as the promotion code only in a cycle where sel_we_i and imask_i are both 1. A write made with imask_i at 0 has no effect.
- R10: irq_o and vec_o show the arbitration of the inputs from the previous clock edge. A stored promotion code takes effect for requests sampled on the following edge.
- R11: While irq_o is 1 and ack_i is 0, irq_o and vec_o hold their values. In any other cycle, both load the current result, and vec_o is 0 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 20 | Raw maskable requests, one per source |
| en_i | input | 18 | Local enables; the external source has none |
| imask_i | input | 1 | Global mask; 1 blocks all sources |
| sel_we_i | input | 1 | Promotion code write strobe |
| sel_wdata_i | input | 4 | Promotion code write data |
| ack_i | input | 1 | Consumer acknowledge of the presented vector |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 4 | Registered winning vector number |

## Verification
A change on the request, enable or mask inputs appears on irq_o and vec_o exactly one clock edge later. A promotion write needs one edge to be stored and one more edge to reach the outputs. The bench drives every input on the falling edge and steps a cycle model of the promotion code and the output registers on each rising edge. It compares the outputs on the next falling edge, so each result is sampled in the cycle it is due. Held vectors are compared against the model's frozen copy until the acknowledge cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // Vector that carries a given source.
   // Layout: external source first, then solo sources, then the shared pair,
   // then the serial group.
   function automatic int src_to_vec(input int s, input int n_solo, input int n_duo);
      if (s <= n_solo)
         return s;
      else if (s <= n_solo + n_duo)
         return n_solo + 1;
      else
         return n_solo + 2;
   endfunction

   // Local enable index of a source (s >= 1). The last source reuses the
   // enable of the one before it.
   function automatic int src_to_en(input int s, input int n_src);
      int t;
      t = (s < n_src - 1) ? s : n_src - 2;
      return t - 1;
   endfunction

   typedef enum logic [0:0] {
      ARB_FIXED    = 1'b0,
      ARB_PROMOTED = 1'b1
   } arb_path_e;

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
   import irq_prio_pkg::*;
#(
   parameter int N_SOLO = 12,
   parameter int N_DUO  = 2,
   parameter int N_SER  = 5,
   localparam int N_SRC = 1 + N_SOLO + N_DUO + N_SER,
   localparam int N_EN  = N_SRC - 2,
   localparam int N_VEC = N_SOLO + 3
) (
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_EN-1:0]  en_i,
   input  logic             imask_i,
   output logic [N_VEC-1:0] vreq_o
);

   logic [N_SRC-1:0] eff;

   // Per-source qualification by local enable
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      if (s == 0) begin : g_ext
         assign eff[s] = req_i[s];
      end else begin : g_loc
         assign eff[s] = req_i[s] & en_i[src_to_en(s, N_SRC)];
      end
   end

   // Fold qualified sources onto vectors, then apply the global mask
   for (genvar v = 0; v < N_VEC; v++) begin : g_vec
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int s = 0; s < N_SRC; s++) begin
            if (src_to_vec(s, N_SOLO, N_DUO) == v)
               hit = hit | eff[s];
         end
      end
      assign vreq_o[v] = hit & ~imask_i;
   end

endmodule

// File: rtl/irq_prom_reg.sv
module irq_prom_reg #(
   parameter int          SEL_W = 4,
   parameter logic [SEL_W-1:0] RST_CODE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             imask_i,
   input  logic             we_i,
   input  logic [SEL_W-1:0] wdata_i,
   output logic [SEL_W-1:0] sel_o
);

   logic [SEL_W-1:0] sel_q;
   logic             wr_ok;

   // Writes are locked out unless the global mask is set
   assign wr_ok = we_i & imask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= RST_CODE;
      else if (wr_ok)
         sel_q <= wdata_i;
   end

   assign sel_o = sel_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int N_VEC   = 15,
   parameter int SEL_W   = 4,
   parameter bit PROMOTE = 1'b1
) (
   input  logic [N_VEC-1:0] vreq_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             any_o,
   output logic [SEL_W-1:0] win_o
);

   logic [SEL_W-1:0] dflt;
   arb_path_e        path;

   assign any_o = |vreq_i;

   // Fixed order: lowest vector number wins
   always_comb begin
      dflt = '0;
      for (int v = N_VEC - 1; v >= 0; v--) begin
         if (vreq_i[v])
            dflt = SEL_W'(v);
      end
   end

   if (PROMOTE) begin : g_prom
      logic sel_valid;
      logic sel_pend;
      assign sel_valid = (32'(sel_i) < N_VEC);
      always_comb begin
         sel_pend = 1'b0;
         for (int v = 0; v < N_VEC; v++) begin
            if (32'(sel_i) == v)
               sel_pend = vreq_i[v];
         end
      end
      assign path = (sel_valid && sel_pend) ? ARB_PROMOTED : ARB_FIXED;
   end else begin : g_fixed
      assign path = ARB_FIXED;
   end

   assign win_o = (path == ARB_PROMOTED) ? sel_i : dflt;

endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
   import irq_prio_pkg::*;
#(
   parameter int N_SOLO  = 12,
   parameter int N_DUO   = 2,
   parameter int N_SER   = 5,
   parameter int SEL_W   = 4,
   parameter bit PROMOTE = 1'b1,
   localparam int N_SRC  = 1 + N_SOLO + N_DUO + N_SER,
   localparam int N_EN   = N_SRC - 2,
   localparam int N_VEC  = N_SOLO + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_EN-1:0]  en_i,
   input  logic             imask_i,
   input  logic             sel_we_i,
   input  logic [SEL_W-1:0] sel_wdata_i,
   input  logic             ack_i,
   output logic             irq_o,
   output logic [SEL_W-1:0] vec_o
);

   // Elaboration-time parameter checks
   if (N_SOLO < 1) begin : g_chk_solo
      $error("irq_prioritizer: N_SOLO must be at least 1");
   end
   if (N_DUO < 1) begin : g_chk_duo
      $error("irq_prioritizer: N_DUO must be at least 1");
   end
   if (N_SER < 2) begin : g_chk_ser
      $error("irq_prioritizer: N_SER must be at least 2 for the shared enable");
   end
   if ((1 << SEL_W) < N_VEC) begin : g_chk_selw
      $error("irq_prioritizer: SEL_W too narrow for N_VEC");
   end

   logic [N_VEC-1:0] vreq;
   logic [SEL_W-1:0] sel_q;
   logic             any;
   logic [SEL_W-1:0] win;
   logic             irq_q;
   logic [SEL_W-1:0] vec_q;

   irq_src_gate #(
      .N_SOLO (N_SOLO),
      .N_DUO  (N_DUO),
      .N_SER  (N_SER)
   ) u_gate (
      .req_i   (req_i),
      .en_i    (en_i),
      .imask_i (imask_i),
      .vreq_o  (vreq)
   );

   irq_prom_reg #(
      .SEL_W    (SEL_W),
      .RST_CODE ('0)
   ) u_prom (
      .clk     (clk),
      .rst_n   (rst_n),
      .imask_i (imask_i),
      .we_i    (sel_we_i),
      .wdata_i (sel_wdata_i),
      .sel_o   (sel_q)
   );

   irq_arbiter #(
      .N_VEC   (N_VEC),
      .SEL_W   (SEL_W),
      .PROMOTE (PROMOTE)
   ) u_arb (
      .vreq_i (vreq),
      .sel_i  (sel_q),
      .any_o  (any),
      .win_o  (win)
   );

   // Output stage: frozen while presented and not yet acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else if (!irq_q || ack_i) begin
         irq_q <= any;
         vec_q <= win;
      end
   end

   assign irq_o = irq_q;
   assign vec_o = vec_q;

endmodule

// File: rtl/irq_prioritizer_chk.sv
module irq_prioritizer_chk #(
   parameter int SEL_W = 4,
   parameter int N_SRC = 20,
   parameter int N_VEC = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] req_i,
   input logic             imask_i,
   input logic             sel_we_i,
   input logic [SEL_W-1:0] sel_wdata_i,
   input logic             ack_i,
   input logic             irq_o,
   input logic [SEL_W-1:0] vec_o,
   input logic [SEL_W-1:0] sel_q
);

   // R2: mask blocks a new request
   a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && imask_i) |=> !irq_o);

   // R3: the external source needs no enable
   a_r3_ext_unenabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && req_i[0] && !imask_i) |=> irq_o);

   // R9: write accepted under mask
   a_r9_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we_i && imask_i) |=> (sel_q == $past(sel_wdata_i)));

   // R9: code unchanged otherwise
   a_r9_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_we_i && imask_i) |=> $stable(sel_q));

   // R11: hold until acknowledge
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

   // R11: idle vector number is 0
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && req_i == '0) |=> (!irq_o && vec_o == '0));

   // R5: vector number in range
   a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (32'(vec_o) < N_VEC));

endmodule

bind irq_prioritizer irq_prioritizer_chk #(
   .SEL_W (SEL_W),
   .N_SRC (N_SRC),
   .N_VEC (N_VEC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .imask_i     (imask_i),
   .sel_we_i    (sel_we_i),
   .sel_wdata_i (sel_wdata_i),
   .ack_i       (ack_i),
   .irq_o       (irq_o),
   .vec_o       (vec_o),
   .sel_q       (sel_q)
);

// File: tb/irq_prioritizer_tb.sv
module irq_prioritizer_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] req = '0;
   logic [17:0] en = '0;
   logic        imask = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  wdata = '0;
   logic        ack = 1'b0;
   logic        irq;
   logic [3:0]  vec;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // Bench model state
   logic       m_irq = 1'b0;
   logic [3:0] m_vec = '0;
   logic [3:0] m_sel = '0;

   always #(CLK_P/2) clk = ~clk;

   irq_prioritizer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .en_i        (en),
      .imask_i     (imask),
      .sel_we_i    (we),
      .sel_wdata_i (wdata),
      .ack_i       (ack),
      .irq_o       (irq),
      .vec_o       (vec)
   );

   // Vector requests as the requirements define them (R3, R4, R5)
   function automatic logic [14:0] m_vreq(input logic [19:0] r, input logic [17:0] e);
      logic [14:0] vr;
      vr = '0;
      for (int s = 0; s < 20; s++) begin
         logic act;
         int   vn;
         if (s == 0)       act = r[s];
         else if (s <= 18) act = r[s] & e[s-1];
         else              act = r[s] & e[17];
         if (s <= 12)      vn = s;
         else if (s <= 14) vn = 13;
         else              vn = 14;
         if (act) vr[vn] = 1'b1;
      end
      return vr;
   endfunction

   // Winner per R6, R7, R8
   function automatic logic [3:0] m_win(input logic [14:0] vr, input logic [3:0] sel);
      if (sel < 4'd15 && vr[sel]) return sel;
      for (int v = 0; v < 15; v++)
         if (vr[v]) return 4'(v);
      return 4'd0;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One clock: model advances on the edge, outputs compared at the next falling edge (R10)
   task automatic step(input string tag);
      logic [14:0] vr;
      logic        ni;
      logic [3:0]  nv;
      logic [3:0]  ns;
      vr = imask ? 15'd0 : m_vreq(req, en);
      if (!m_irq || ack) begin
         ni = |vr;
         nv = m_win(vr, m_sel);
      end else begin
         ni = m_irq;
         nv = m_vec;
      end
      ns = (we && imask) ? wdata : m_sel;
      @(posedge clk);
      @(negedge clk);
      m_irq = ni;
      m_vec = nv;
      m_sel = ns;
      chk(irq == ni, tag, "irq_o", int'(irq), int'(ni));
      chk(vec == nv, tag, "vec_o", int'(vec), int'(nv));
   endtask

   task automatic idle_inputs();
      req = '0; en = '0; imask = 1'b0; we = 1'b0; wdata = '0; ack = 1'b0;
   endtask

   task automatic drain();
      idle_inputs();
      ack = 1'b1;
      step("R11");
      step("R11");
      ack = 1'b0;
   endtask

   task automatic write_sel(input logic [3:0] code);
      idle_inputs();
      imask = 1'b1; we = 1'b1; wdata = code;
      step("R9");
      idle_inputs();
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog R10: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(irq == 1'b0, "R1", "irq_o in reset", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq == 1'b0, "R1", "irq_o after reset", int'(irq), 0);
      chk(vec == 4'd0, "R1", "vec_o after reset", int'(vec), 0);

      // R1: reset code promotes vector 0, same as default; R6
      req = '0; req[12] = 1'b1; req[1] = 1'b1; en = '1;
      step("R1");
      chk(vec == 4'd1, "R6", "lowest wins", int'(vec), 1);
      drain();

      // R2: mask blocks everything
      req = '1; en = '1; imask = 1'b1;
      step("R2");
      step("R2");
      drain();

      // R3: disabled local source is ignored; external has no enable
      req[5] = 1'b1; en[4] = 1'b0;
      step("R3");
      chk(irq == 1'b0, "R3", "disabled source", int'(irq), 0);
      req = '0; req[0] = 1'b1; en = '0;
      step("R3");
      chk(irq && vec == 4'd0, "R3", "external vector", int'(vec), 0);
      drain();

      // R4: serial group and shared enable
      req[19] = 1'b1; en[17] = 1'b1;
      step("R4");
      chk(vec == 4'd14, "R4", "receive full vector", int'(vec), 14);
      drain();
      req[18] = 1'b1; en[17] = 1'b1;
      step("R4");
      chk(vec == 4'd14, "R4", "overrun vector", int'(vec), 14);
      drain();
      req[19] = 1'b1; req[18] = 1'b1; en = '1; en[17] = 1'b0;
      step("R4");
      chk(irq == 1'b0, "R4", "shared enable off", int'(irq), 0);
      drain();

      // R5: shared pair
      req[14] = 1'b1; en[13] = 1'b1;
      step("R5");
      chk(vec == 4'd13, "R5", "pair vector", int'(vec), 13);
      drain();

      // R7: promote vector 14 above vector 1
      write_sel(4'd14);
      req[1] = 1'b1; req[16] = 1'b1; en = '1;
      step("R7");
      chk(vec == 4'd14, "R7", "promoted wins", int'(vec), 14);
      drain();

      // R8: code 15 names nothing
      write_sel(4'd15);
      req[7] = 1'b1; req[2] = 1'b1; en = '1;
      step("R8");
      chk(vec == 4'd2, "R8", "invalid code default", int'(vec), 2);
      drain();

      // R9: write with mask clear is dropped
      write_sel(4'd5);
      we = 1'b1; wdata = 4'd9;
      step("R9");
      idle_inputs();
      req[3] = 1'b1; req[5] = 1'b1; req[9] = 1'b1; en = '1;
      step("R9");
      chk(vec == 4'd5, "R9", "locked write", int'(vec), 5);
      drain();

      // R10: fresh code acts on the next sampled requests
      write_sel(4'd0);
      req[4] = 1'b1; en = '1;
      step("R10");
      chk(irq && vec == 4'd4, "R10", "one-edge latency", int'(vec), 4);
      drain();

      // R11: hold until acknowledge
      req[8] = 1'b1; en = '1;
      step("R11");
      req[1] = 1'b1;
      step("R11");
      chk(vec == 4'd8, "R11", "held vector", int'(vec), 8);
      ack = 1'b1;
      step("R11");
      chk(vec == 4'd1, "R11", "reload on ack", int'(vec), 1);
      drain();

      // Random traffic: R6, R7, R9, R10, R11 via the model
      for (int i = 0; i < 3000; i++) begin
         req   = 20'($urandom) & 20'($urandom) & 20'($urandom);
         en    = 18'($urandom) | 18'($urandom);
         imask = ($urandom % 5) == 0;
         we    = ($urandom % 7) == 0;
         wdata = 4'($urandom);
         ack   = ($urandom % 3) == 0;
         step("R6");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule